// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is one cell of a programmable-logic array. It takes five product-term inputs and a sum-of-products input from neighbouring cells, and it is set up by a static configuration word. From these it produces a data output and an output-enable. The configuration word sets how each product term is used, and the output can be taken straight from the logic or through a storage element.

A product term can feed the OR sum. It can also be taken out of the OR and used as a local control for the cell: clock, set, reset, output enable or clock enable. An XOR stage after the OR gives a selectable polarity. The storage element works as D-type or toggle-type. Its clock is one of three global clocks or a product term, and that clock can be inverted locally. The element can be set or cleared asynchronously by product terms or by the global set/reset line. While the power-on input is low, it holds a configured preload value.

Top module: `mc_cell`

## Requirements
- R1: The data sum is the OR of `sum_in` and every product term `pt[i]` whose steer bit `cfg[i]` (bits 4..0) is 0. A steer bit of 1 removes that term from the sum.
- R2: The D/T input is the sum XORed with an operand chosen by `cfg[15:14]`: 0 gives constant 0, 1 gives constant 1, 2 gives `pt[4]`, 3 gives the inverse of `pt[4]`.
- R3: When `cfg[17]`=0, `mc_out` is the register, which loads the D/T input on each active clock edge. When `cfg[17]`=1, `mc_out` shows the D/T input directly, with no clock edge needed.
- R4: When `cfg[16]`=1, the register toggles on an active edge if the D/T input is 1 and holds if it is 0.
- R5: When `cfg[11]`=1, `pt[4]` acts as clock enable, and an active edge with `pt[4]`=0 leaves the register unchanged. When `cfg[11]`=0, the register is always enabled.
- R6: `cfg[6:5]` picks the register clock: values 0, 1 and 2 select `gclk[0]`, `gclk[1]` and `gclk[2]`, and 3 selects `pt[0]`. When `cfg[7]`=1, the chosen clock is inverted, so its falling edge is the active edge.
- R7: When `cfg[8]`=1, `pt[1]` sets the register asynchronously. When `cfg[9]`=1, `pt[2]` clears it asynchronously. If both are asserted together, the clear wins.
- R8: A high `gsr` sets the register asynchronously when `cfg[10]`=1 and clears it when `cfg[10]`=0.
- R9: While `por_n` is low, the register holds `cfg[18]` and ignores clocks.
- R10: `cfg[13:12]` picks `mc_oe`: 0 gives `goe`, 1 gives `pt[3]`, 2 gives constant 1, 3 gives constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on, active low; loads the preload value |
| gclk | input | 3 | Global clocks |
| gsr | input | 1 | Global asynchronous set/reset |
| goe | input | 1 | Global output enable |
| cfg | input | 19 | Static configuration word |
| pt | input | 5 | Product-term inputs |
| sum_in | input | 1 | Sum-of-products from neighbouring cells |
| mc_out | output | 1 | Cell data output |
| mc_oe | output | 1 | Cell output enable |

## Verification
The data path is driven by single product terms, by the neighbour sum alone, and by a steered term whose removal turns a 1 into a 0. This shows the OR-gating apart from plain pass-through. The register is clocked from the running global clock, from a manually toggled inverted global clock while the running clock keeps ticking, and from a product term. Only the selected source may change the output. Set and clear are asserted alone and together with the opposite data on the D input, which shows that the asynchronous paths and the clear priority beat the clocked load. The toggle sequences run with the enable on and off, which shows toggling, holding and gating apart.

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NPT   = 5,
  parameter int NGCLK = 3,
  parameter int CFG_W = 19
) (
  input  logic             por_n,
  input  logic [NGCLK-1:0] gclk,
  input  logic             gsr,
  input  logic             goe,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NPT-1:0]   pt,
  input  logic             sum_in,
  output logic             mc_out,
  output logic             mc_oe
);
  localparam int CLK_LO = NPT;
  localparam int INV_B  = NPT + 2;
  localparam int SETP_B = NPT + 3;
  localparam int RSTP_B = NPT + 4;
  localparam int GSRS_B = NPT + 5;
  localparam int CEP_B  = NPT + 6;
  localparam int OE_LO  = NPT + 7;
  localparam int XOR_LO = NPT + 9;
  localparam int TGL_B  = NPT + 11;
  localparam int CMB_B  = NPT + 12;
  localparam int PRE_B  = NPT + 13;

  logic [NPT-1:0] steer;
  logic [1:0]     clk_sel, oe_sel, xor_sel;
  logic           sum, xop, d, clk_raw, rclk, ce;
  logic           want_clr, want_set, aclr, aset, q;

  assign steer   = cfg[NPT-1:0];
  assign clk_sel = cfg[CLK_LO+1:CLK_LO];
  assign oe_sel  = cfg[OE_LO+1:OE_LO];
  assign xor_sel = cfg[XOR_LO+1:XOR_LO];

  assign sum = (|(pt & ~steer)) | sum_in;

  always_comb
    case (xor_sel)
      2'd0:    xop = 1'b0;
      2'd1:    xop = 1'b1;
      2'd2:    xop = pt[4];
      default: xop = ~pt[4];
    endcase

  assign d = sum ^ xop;

  always_comb
    case (clk_sel)
      2'd0:    clk_raw = gclk[0];
      2'd1:    clk_raw = gclk[1];
      2'd2:    clk_raw = gclk[2];
      default: clk_raw = pt[0];
    endcase

  assign rclk = clk_raw ^ cfg[INV_B];
  assign ce   = cfg[CEP_B] ? pt[4] : 1'b1;

  assign want_clr = (cfg[RSTP_B] & pt[2]) | (gsr & ~cfg[GSRS_B]);
  assign want_set = (cfg[SETP_B] & pt[1]) | (gsr & cfg[GSRS_B]);
  assign aclr = por_n ? want_clr : ~cfg[PRE_B];
  assign aset = por_n ? (want_set & ~want_clr) : cfg[PRE_B];

  always_ff @(posedge rclk or posedge aclr or posedge aset)
    if (aclr)      q <= 1'b0;
    else if (aset) q <= 1'b1;
    else if (ce)   q <= cfg[TGL_B] ? (q ^ d) : d;

  assign mc_out = cfg[CMB_B] ? d : q;

  always_comb
    case (oe_sel)
      2'd0:    mc_oe = goe;
      2'd1:    mc_oe = pt[3];
      2'd2:    mc_oe = 1'b1;
      default: mc_oe = 1'b0;
    endcase
endmodule

module mc_cell_chk (
  input logic        por_n,
  input logic [2:0]  gclk,
  input logic        gsr,
  input logic [18:0] cfg,
  input logic [4:0]  pt,
  input logic        sum_in,
  input logic        mc_out,
  input logic        mc_oe
);
  // R7
  clr_wins_chk: assert property (@(posedge gclk[0]) disable iff (!por_n)
    (cfg[9] && pt[2] && !cfg[17]) |-> !mc_out);

  // R10
  oe_forced_chk: assert property (@(posedge gclk[0]) disable iff (!por_n)
    (cfg[13:12] == 2'd3) |-> !mc_oe);

  // R3
  comb_pass_chk: assert property (@(posedge gclk[0]) disable iff (!por_n)
    (cfg[17] && cfg[15:14] == 2'd0 && sum_in) |-> mc_out);

  // R5
  ce_hold_chk: assert property (@(posedge gclk[0]) disable iff (!por_n)
    (!cfg[17] && cfg[11] && !pt[4] && cfg[6:5] == 2'd0 && !cfg[7])
    |=> ($stable(mc_out) || !$stable(cfg) || !$stable(pt) || gsr
         || (cfg[8] && pt[1]) || (cfg[9] && pt[2])));
endmodule

bind mc_cell mc_cell_chk u_chk (
  .por_n(por_n), .gclk(gclk), .gsr(gsr), .cfg(cfg), .pt(pt),
  .sum_in(sum_in), .mc_out(mc_out), .mc_oe(mc_oe)
);

// File: tb/mc_cell_tb.sv
module mc_cell_tb;
  typedef struct {
    logic  o;
    logic  e;
    string tag;
  } exp_t;

  logic clk = 0;
  always #4 clk = ~clk;

  logic        por_n = 0, gsr = 0, goe = 0, sum_in = 0;
  logic        g1 = 0, g2 = 0;
  logic [4:0]  pt = 0;
  logic [4:0]  c_steer = 0;
  logic [1:0]  c_clk = 0, c_oe = 2, c_xor = 0;
  logic        c_inv = 0, c_setpt = 0, c_rstpt = 0, c_gsrset = 0, c_cept = 0;
  logic        c_t = 0, c_comb = 0, c_pre = 1;
  logic [18:0] cfg;
  logic        mc_out, mc_oe;

  assign cfg = {c_pre, c_comb, c_t, c_xor, c_oe, c_cept, c_gsrset,
                c_rstpt, c_setpt, c_inv, c_clk, c_steer};

  mc_cell u_dut (
    .por_n(por_n), .gclk({g2, g1, clk}), .gsr(gsr), .goe(goe), .cfg(cfg),
    .pt(pt), .sum_in(sum_in), .mc_out(mc_out), .mc_oe(mc_oe)
  );

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic o, input logic e, input string tag);
    exp_t x;
    x.o = o; x.e = e; x.tag = tag;
    sb.push_back(x);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (mc_out !== x.o || mc_oe !== x.e) begin
          errors++;
          $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b",
                   x.tag, mc_out, mc_oe, x.o, x.e);
        end
      end
    end
  end

  initial begin
    tick(); push(1, 1, "R9 preload one");
    tick(); c_pre = 0; push(0, 1, "R9 preload zero");
    tick(); por_n = 1; push(0, 1, "R3 after power-on");

    tick(); pt = 5'b00100; push(1, 1, "R1 single term");
    tick(); pt = 0; sum_in = 1; push(1, 1, "R1 neighbour sum");
    tick(); sum_in = 0; push(0, 1, "R1 all zero");
    tick(); c_steer = 5'b00100; pt = 5'b00100; push(0, 1, "R1 steered term removed");
    tick(); c_steer = 0; pt = 0; c_xor = 1; push(1, 1, "R2 const one inverts");
    tick(); c_xor = 2; c_steer = 5'b10000; pt = 5'b10000; sum_in = 1; push(0, 1, "R2 pt4 operand high");
    tick(); pt = 0; push(1, 1, "R2 pt4 operand low");
    tick(); c_xor = 3; push(0, 1, "R2 inverted pt4 operand");
    tick(); c_xor = 0; c_steer = 0; sum_in = 0; push(0, 1, "R3 clear data");

    tick(); c_clk = 1; c_comb = 1; sum_in = 1; push(1, 1, "R3 combinational bypass");
    tick(); c_comb = 0; push(0, 1, "R3 register unclocked");
    tick(); c_clk = 0; sum_in = 0; push(0, 1, "R3 back to gclk0");

    tick(); c_t = 1; sum_in = 1; push(1, 1, "R4 toggle to one");
    tick(); push(0, 1, "R4 toggle to zero");
    tick(); push(1, 1, "R4 toggle to one again");
    tick(); sum_in = 0; push(1, 1, "R4 hold on zero");
    tick(); c_cept = 1; c_steer = 5'b10000; pt = 0; sum_in = 1; push(1, 1, "R5 enable low holds");
    tick(); push(1, 1, "R5 enable low still holds");
    tick(); pt = 5'b10000; push(0, 1, "R5 enable high toggles");
    tick(); c_cept = 0; c_t = 0; c_steer = 0; pt = 0; sum_in = 0; push(0, 1, "R4 D mode restored");

    tick(); c_setpt = 1; c_rstpt = 1; c_steer = 5'b00110; pt = 5'b00010; push(1, 1, "R7 async set");
    tick(); pt = 5'b00110; push(0, 1, "R7 clear wins over set");
    tick(); pt = 0; push(0, 1, "R7 release");
    tick(); sum_in = 1; pt = 5'b00100; push(0, 1, "R7 clear beats data one");
    tick(); pt = 0; push(1, 1, "R7 clock after clear");
    tick(); c_setpt = 0; c_rstpt = 0; c_steer = 0; gsr = 1; c_gsrset = 0; push(0, 1, "R8 global clear");
    tick(); c_gsrset = 1; sum_in = 0; push(1, 1, "R8 global set");
    tick(); gsr = 0; push(0, 1, "R8 release");

    g1 = 1;
    tick(); c_clk = 1; c_inv = 1; sum_in = 1; push(0, 1, "R6 gclk0 ignored");
    tick(); g1 = 0; push(1, 1, "R6 inverted gclk1 falling edge");
    tick(); sum_in = 0; push(1, 1, "R6 no gclk1 edge holds");
    tick(); g1 = 1; push(1, 1, "R6 gclk1 rising inactive");
    tick(); g1 = 0; push(0, 1, "R6 second falling edge");
    tick(); c_clk = 3; c_inv = 0; c_steer = 5'b00001; pt = 0; sum_in = 1; push(0, 1, "R6 pt clock idle");
    tick(); pt = 5'b00001; push(1, 1, "R6 pt0 rising edge");
    tick(); sum_in = 0; push(1, 1, "R6 pt0 held high");
    tick(); pt = 0; push(1, 1, "R6 pt0 falling inactive");
    tick(); pt = 5'b00001; push(0, 1, "R6 pt0 second edge");
    tick(); pt = 0; c_clk = 0; c_steer = 0; push(0, 1, "R6 back to gclk0");

    tick(); c_oe = 0; goe = 0; push(0, 0, "R10 global oe low");
    tick(); goe = 1; push(0, 1, "R10 global oe high");
    tick(); c_oe = 1; c_steer = 5'b01000; pt = 5'b01000; push(0, 1, "R10 pt3 oe high");
    tick(); pt = 0; push(0, 0, "R10 pt3 oe low");
    tick(); c_oe = 3; pt = 5'b01000; push(0, 0, "R10 forced off");

    repeat (3) tick();
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule